// File: doc/BRIEF.md
# BCD Real-Time Clock Timekeeper

This block holds calendar time in seven packed-BCD registers: seconds, minutes, hours, day of week, date, month and year. A control register selects a square-wave output. A single reference-enable input drives everything. It pulses once per half-period of a 32.768 kHz reference, so 2^DIV_W pulses make one second; the default DIV_W of 16 gives 65536 pulses per second. A binary divider counts these pulses. When the divider wraps, a one-second advance ripples through the BCD carry chain. The chain honours month lengths, leap years and either a 24-hour or a 12-hour AM/PM hour format.

An external serial-bus slave, which is not part of this block, reaches the registers through a plain register port. Writes take effect on the clock edge. Reads are combinational on the address. Writing the seconds register restarts the sub-second count, so software can align the second boundary. The square-wave output is taken from divider bits, so it stays phase-locked to the second boundary.

Top module: `rtc_bcd_core`

## Requirements
- R1: After synchronous reset, addresses 0..7 read 0x00, 0x00, 0x40, 0x01, 0x01, 0x01, 0x00, 0x00 (24-hour midnight, day 1, 1 January, year 00, square wave off), and `sqw_out` is 0.
- R2: The seconds register (address 0, BCD 00..59) advances by one in BCD every 2^DIV_W `ref_en` pulses. 0x09 goes to 0x10, and 0x59 goes to 0x00 with a carry into minutes.
- R3: The minutes register (address 1, BCD 00..59) advances on a seconds carry, and 0x59 goes to 0x00 with a carry into hours.
- R4: Hours is address 2, and bit 6 = 1 selects 24-hour mode. In that mode, bits 5:0 hold BCD 00..23 and bit 5 is the upper tens-of-hours bit. 0x63 (23 h) goes to 0x40 and carries into the day and date.
- R5: Bit 6 = 0 selects 12-hour mode. In that mode, bit 5 is the PM flag (1 = PM) and bits 4:0 hold BCD 01..12. Hour 11 goes to 12 and toggles the flag. Hour 12 goes to 01 and keeps the flag. Only 11 PM to 12 AM carries into the day and date.
- R6: Day of week (address 3) counts 1..7 and wraps from 7 to 1 on an hour carry.
- R7: Date (address 4) wraps to 01 after the month's last day. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the BCD year is divisible by 4, and 28 otherwise. All other months have 31 days.
- R8: Month (address 5) wraps from 12 to 01 with a carry into year (address 6), and year wraps from 99 to 00.
- R9: A write to address N stores the data masked to that field's bits. The masks are: seconds and minutes 0x7F, hours 0x7F, day 0x07, date 0x3F, month 0x1F, year 0xFF, control 0x13 (bit 4 enable, bits 1:0 rate). Masked bits read as 0.
- R10: A write in the cycle where a second completes takes priority. Only the written field changes, and that second's advance is discarded.
- R11: Writing the seconds register clears the divider. The next advance follows exactly 2^DIV_W further `ref_en` pulses.
- R12: With control bit 4 = 0, `sqw_out` is 0. With bit 4 = 1, `sqw_out` follows a divider bit chosen by rate:
  - 00: 1 Hz (divider MSB)
  - 01: 4.096 kHz (bit 3)
  - 10: 8.192 kHz (bit 2)
  - 11: 32.768 kHz (bit 0)

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_en | input | 1 | Enable pulse, one per reference half-period |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address, 0..7 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| sqw_out | output | 1 | Square-wave output |

## Verification
The checker assumes that every register write carries a value legal for its field. That means:
- BCD digits within range for seconds, minutes, hours and day;
- a 12-hour value between 01 and 12;
- a date no later than the month's last day.

Under these assumptions the range and carry properties describe every reachable state. The random stimulus draws each written value from that field's legal range, with date writes limited to 01..28. High-order junk bits are added only where the mask removes them. Month-end dates are written only by the directed cases, together with a matching month and year.

// File: rtl/rtc_pkg.sv
// Shared definitions for the BCD timekeeper: register addresses, write
// masks, the square-wave rate encoding and small BCD helper functions.
// Assumes every BCD argument holds legal digits (0..9 per nibble).
package rtc_pkg;

    typedef enum logic [1:0] {
        RATE_1HZ  = 2'b00,
        RATE_4K   = 2'b01,
        RATE_8K   = 2'b10,
        RATE_32K  = 2'b11
    } sqw_rate_e;

    localparam logic [2:0] ADDR_SEC  = 3'd0;
    localparam logic [2:0] ADDR_MIN  = 3'd1;
    localparam logic [2:0] ADDR_HOUR = 3'd2;
    localparam logic [2:0] ADDR_DAY  = 3'd3;
    localparam logic [2:0] ADDR_DATE = 3'd4;
    localparam logic [2:0] ADDR_MON  = 3'd5;
    localparam logic [2:0] ADDR_YEAR = 3'd6;
    localparam logic [2:0] ADDR_CTRL = 3'd7;

    // Bits that each register keeps on a write.
    function automatic logic [7:0] field_mask(input logic [2:0] addr);
        case (addr)
            ADDR_SEC, ADDR_MIN, ADDR_HOUR: field_mask = 8'h7F;
            ADDR_DAY:                      field_mask = 8'h07;
            ADDR_DATE:                     field_mask = 8'h3F;
            ADDR_MON:                      field_mask = 8'h1F;
            ADDR_YEAR:                     field_mask = 8'hFF;
            default:                       field_mask = 8'h13;
        endcase
    endfunction

    // Packed-BCD increment by one; a 9 in the low digit carries upward.
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9)
            bcd_inc = {v[7:4] + 4'd1, 4'd0};
        else
            bcd_inc = {v[7:4], v[3:0] + 4'd1};
    endfunction

    // True when a two-digit BCD year is a multiple of four.
    function automatic logic year_is_leap(input logic [7:0] yr);
        logic [7:0] bin;
        bin = ({4'd0, yr[7:4]} << 3) + ({4'd0, yr[7:4]} << 1) + {4'd0, yr[3:0]};
        year_is_leap = ((bin & 8'h03) == 8'h00);
    endfunction

    // Last date of a BCD month, returned in BCD.
    function automatic logic [7:0] month_last_date(input logic [7:0] mon,
                                                   input logic [7:0] yr);
        case (mon)
            8'h02:                      month_last_date = year_is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: month_last_date = 8'h30;
            default:                    month_last_date = 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Sub-second divider: counts reference-enable pulses and flags the pulse
// that completes a second. Assumes 2**DIV_W pulses make one second.
module rtc_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_en,
    input  logic             clr,
    output logic             sec_tick,
    output logic [DIV_W-1:0] div_q
);

    // Divider count: restarts on clear, otherwise advances per pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (clr)
            div_q <= '0;
        else if (ref_en)
            div_q <= div_q + 1'b1;
    end

    // Second boundary: the pulse that wraps the count.
    assign sec_tick = ref_en && (&div_q);

endmodule

// File: rtl/rtc_sqw_gen.sv
// Square-wave selector: picks one divider bit according to the rate code
// and gates it with the enable. Assumes DIV_W >= 5 so that the 1 Hz tap
// is distinct from the fixed 4.096 kHz tap.
module rtc_sqw_gen
    import rtc_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic [DIV_W-1:0] div_q,
    input  logic             enable,
    input  sqw_rate_e        rate,
    output logic             sqw
);

    localparam int IW = $clog2(DIV_W);

    logic [IW-1:0] tap;

    // Tap choice: divider bit whose toggle rate matches the code.
    always_comb begin
        case (rate)
            RATE_1HZ: tap = IW'(DIV_W - 1);
            RATE_4K:  tap = IW'(3);
            RATE_8K:  tap = IW'(2);
            default:  tap = '0;
        endcase
    end

    assign sqw = enable & div_q[tap];

endmodule

// File: rtl/rtc_time_chain.sv
// BCD time and calendar registers with their carry chain. A register
// write wins over a second advance in the same cycle. Assumes written
// values are legal BCD for each field.
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       we,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] sec_q,
    output logic [7:0] min_q,
    output logic [7:0] hour_q,
    output logic [7:0] day_q,
    output logic [7:0] date_q,
    output logic [7:0] mon_q,
    output logic [7:0] year_q
);

    logic       sec_last, min_last, hour_last, date_last, mon_last;
    logic [7:0] hour_nxt, inc12, inc24, wval;

    assign wval = wdata & field_mask(addr);

    // Rollover flags for each field of the chain.
    always_comb begin
        sec_last  = (sec_q == 8'h59);
        min_last  = (min_q == 8'h59);
        date_last = (date_q == month_last_date(mon_q, year_q));
        mon_last  = (mon_q == 8'h12);
    end

    // Next hour value and day carry for the mode held in bit 6.
    always_comb begin
        inc12 = bcd_inc(hour_q & 8'h1F);
        inc24 = bcd_inc(hour_q & 8'h3F);
        if (hour_q[6]) begin
            hour_last = ((hour_q & 8'h3F) == 8'h23);
            hour_nxt  = hour_last ? 8'h40 : (inc24 | 8'h40);
        end else begin
            hour_last = hour_q[5] && ((hour_q & 8'h1F) == 8'h11);
            if ((hour_q & 8'h1F) == 8'h12)
                hour_nxt = (hour_q & 8'h20) | 8'h01;
            else if ((hour_q & 8'h1F) == 8'h11)
                hour_nxt = ((hour_q ^ 8'h20) & 8'h20) | 8'h12;
            else
                hour_nxt = (hour_q & 8'h20) | (inc12 & 8'h1F);
        end
    end

    // Register update: reset, then a bus write, then the second advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q  <= 8'h00;
            min_q  <= 8'h00;
            hour_q <= 8'h40;
            day_q  <= 8'h01;
            date_q <= 8'h01;
            mon_q  <= 8'h01;
            year_q <= 8'h00;
        end else if (we) begin
            case (addr)
                ADDR_SEC:  sec_q  <= wval;
                ADDR_MIN:  min_q  <= wval;
                ADDR_HOUR: hour_q <= wval;
                ADDR_DAY:  day_q  <= wval;
                ADDR_DATE: date_q <= wval;
                ADDR_MON:  mon_q  <= wval;
                ADDR_YEAR: year_q <= wval;
                default: ;
            endcase
        end else if (tick) begin
            sec_q <= sec_last ? 8'h00 : bcd_inc(sec_q);
            if (sec_last)
                min_q <= min_last ? 8'h00 : bcd_inc(min_q);
            if (sec_last && min_last)
                hour_q <= hour_nxt;
            if (sec_last && min_last && hour_last) begin
                day_q  <= (day_q == 8'h07) ? 8'h01 : day_q + 8'h01;
                date_q <= date_last ? 8'h01 : bcd_inc(date_q);
            end
            if (sec_last && min_last && hour_last && date_last)
                mon_q <= mon_last ? 8'h01 : bcd_inc(mon_q);
            if (sec_last && min_last && hour_last && date_last && mon_last)
                year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
        end
    end

endmodule

// File: rtl/rtc_bcd_core.sv
// Top of the BCD timekeeper: divider, time chain, control register,
// square-wave selector and the combinational register read mux.
// Assumes ref_en pulses once per half-period of a 32.768 kHz reference.
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_en,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sqw_out
);

    logic             sec_tick;
    logic             sec_wr;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       t_sec, t_min, t_hour, t_day, t_date, t_mon, t_year;
    logic [7:0]       ctrl_q;

    assign sec_wr = reg_we && (reg_addr == ADDR_SEC);

    rtc_prescaler #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_en   (ref_en),
        .clr      (sec_wr),
        .sec_tick (sec_tick),
        .div_q    (div_q)
    );

    rtc_time_chain u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (sec_tick),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .sec_q  (t_sec),
        .min_q  (t_min),
        .hour_q (t_hour),
        .day_q  (t_day),
        .date_q (t_date),
        .mon_q  (t_mon),
        .year_q (t_year)
    );

    // Control register: square-wave enable and rate, masked on write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= 8'h00;
        else if (reg_we && (reg_addr == ADDR_CTRL))
            ctrl_q <= reg_wdata & field_mask(ADDR_CTRL);
    end

    rtc_sqw_gen #(.DIV_W(DIV_W)) u_sqw (
        .div_q  (div_q),
        .enable (ctrl_q[4]),
        .rate   (sqw_rate_e'(ctrl_q[1:0])),
        .sqw    (sqw_out)
    );

    // Read mux: returns the addressed register.
    always_comb begin
        case (reg_addr)
            ADDR_SEC:  reg_rdata = t_sec;
            ADDR_MIN:  reg_rdata = t_min;
            ADDR_HOUR: reg_rdata = t_hour;
            ADDR_DAY:  reg_rdata = t_day;
            ADDR_DATE: reg_rdata = t_date;
            ADDR_MON:  reg_rdata = t_mon;
            ADDR_YEAR: reg_rdata = t_year;
            default:   reg_rdata = ctrl_q;
        endcase
    end

endmodule

// File: rtl/rtc_bcd_checker.sv
// Property checker for the BCD timekeeper, bound to the top. Assumes all
// register writes carry legal values for their field.
module rtc_bcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_en,
    input logic       reg_we,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       sqw_out,
    input logic       sec_tick,
    input logic [7:0] t_sec,
    input logic [7:0] t_min,
    input logic [7:0] t_hour,
    input logic [7:0] t_day,
    input logic [7:0] t_year
);

    p_sec_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (t_sec <= 8'h59) && (t_sec[3:0] <= 4'd9));

    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !reg_we && t_sec == 8'h59) |=> (t_sec == 8'h00));

    p_min_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !reg_we && t_sec == 8'h59 && t_min == 8'h59) |=> (t_min == 8'h00));

    p_hour24_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        t_hour[6] |-> ((t_hour[5:0] <= 6'h23) && (t_hour[3:0] <= 4'd9)));

    p_hour12_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !t_hour[6] |-> ((t_hour[4:0] >= 5'h01) && (t_hour[4:0] <= 5'h12)));

    p_day_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (t_day >= 8'h01) && (t_day <= 8'h07));

    p_year_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd6) |=> (t_year == $past(reg_wdata)));

    p_hold_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !reg_we) |=> ($stable(t_sec) && $stable(t_min) && $stable(t_hour)));

    p_div_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0) |=> !sec_tick);

    p_sqw_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_en && !reg_we) |=> $stable(sqw_out));

endmodule

bind rtc_bcd_core rtc_bcd_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_en    (ref_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sqw_out   (sqw_out),
    .sec_tick  (sec_tick),
    .t_sec     (t_sec),
    .t_min     (t_min),
    .t_hour    (t_hour),
    .t_day     (t_day),
    .t_year    (t_year)
);

// File: tb/rtc_bcd_core_tb_top.sv
`timescale 1ns/1ps
// Bench for the BCD timekeeper: a reference model written from the
// requirements runs cycle by cycle. Every register and the square wave
// are compared after each step.
module rtc_bcd_core_tb_top;

    localparam int DIV_W = 5;
    localparam int DIV_N = 1 << DIV_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_en = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sqw_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m [0:7];
    int         mdiv;

    rtc_bcd_core #(.DIV_W(DIV_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_en    (ref_en),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sqw_out   (sqw_out)
    );

    always #5 clk = ~clk;

    function automatic int b2i(input logic [7:0] v);
        return int'(v[7:4]) * 10 + int'(v[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    function automatic int mlen(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] wmask(input int a);
        case (a)
            0, 1, 2: return 8'h7F;
            3:       return 8'h07;
            4:       return 8'h3F;
            5:       return 8'h1F;
            6:       return 8'hFF;
            default: return 8'h13;
        endcase
    endfunction

    // One-second advance of the model, done in binary arithmetic.
    task automatic model_advance();
        int s, mi, h, d, dt, mo;
        logic pm;
        s = b2i(m[0]) + 1;
        if (s < 60) begin m[0] = i2b(s); return; end
        m[0] = 8'h00;
        mi = b2i(m[1]) + 1;
        if (mi < 60) begin m[1] = i2b(mi); return; end
        m[1] = 8'h00;
        if (m[2][6]) begin
            h = b2i({2'b00, m[2][5:0]}) + 1;
            if (h < 24) begin m[2] = 8'h40 | i2b(h); return; end
            m[2] = 8'h40;
        end else begin
            h = b2i({3'b000, m[2][4:0]});
            pm = m[2][5];
            if (h == 12) begin m[2] = {2'b00, pm, 5'h01}; return; end
            if (h == 11) begin
                m[2] = {2'b00, ~pm, 5'h12};
                if (!pm) return;
            end else begin
                m[2] = {2'b00, pm, 5'h00} | i2b(h + 1);
                return;
            end
        end
        d = int'(m[3]) + 1;
        m[3] = (d > 7) ? 8'h01 : 8'(d);
        dt = b2i(m[4]) + 1;
        if (dt <= mlen(b2i(m[5]), b2i(m[6]))) begin m[4] = i2b(dt); return; end
        m[4] = 8'h01;
        mo = b2i(m[5]) + 1;
        if (mo <= 12) begin m[5] = i2b(mo); return; end
        m[5] = 8'h01;
        m[6] = i2b((b2i(m[6]) + 1) % 100);
    endtask

    task automatic model_step(input bit r, input bit w, input int a, input logic [7:0] d);
        bit tick;
        tick = r && (mdiv == DIV_N - 1);
        if (w) m[a] = d & wmask(a);
        else if (tick) model_advance();
        if (w && a == 0) mdiv = 0;
        else if (r) mdiv = (mdiv + 1) % DIV_N;
    endtask

    function automatic logic exp_sqw();
        int tap;
        case (m[7][1:0])
            2'b00: tap = DIV_W - 1;
            2'b01: tap = 3;
            2'b10: tap = 2;
            default: tap = 0;
        endcase
        return m[7][4] ? 1'((mdiv >> tap) & 1) : 1'b0;
    endfunction

    task automatic check(input string phase, input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s %s: actual %h expected %h", phase, req, what, act, exp);
        end
    endtask

    // Read every register through the port and compare to the model.
    task automatic compare_all(input string phase);
        string req;
        for (int i = 0; i < 8; i++) begin
            reg_addr = 3'(i);
            #0.5;
            case (i)
                0: req = "R2";
                1: req = "R3";
                2: req = m[2][6] ? "R4" : "R5";
                3: req = "R6";
                4: req = "R7";
                5: req = "R8";
                6: req = "R8";
                default: req = "R9";
            endcase
            check(phase, req, $sformatf("reg%0d", i), reg_rdata, m[i]);
        end
        check(phase, "R12", "sqw", {7'd0, sqw_out}, {7'd0, exp_sqw()});
    endtask

    task automatic step(input bit r, input bit w, input int a, input logic [7:0] d,
                        input string phase);
        ref_en = r; reg_we = w; reg_addr = 3'(a); reg_wdata = d;
        @(posedge clk);
        model_step(r, w, a, d);
        #0.5;
        ref_en = 1'b0; reg_we = 1'b0;
        compare_all(phase);
        @(negedge clk);
    endtask

    task automatic pulses(input int n, input string phase);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 0, 8'h00, phase);
    endtask

    // Load all seven time fields; seconds last so the divider restarts.
    task automatic load(input logic [7:0] hr, input logic [7:0] dy, input logic [7:0] dt,
                        input logic [7:0] mo, input logic [7:0] yr, input logic [7:0] mi,
                        input logic [7:0] s, input string phase);
        step(1'b0, 1'b1, 2, hr, phase);
        step(1'b0, 1'b1, 3, dy, phase);
        step(1'b0, 1'b1, 6, yr, phase);
        step(1'b0, 1'b1, 5, mo, phase);
        step(1'b0, 1'b1, 4, dt, phase);
        step(1'b0, 1'b1, 1, mi, phase);
        step(1'b0, 1'b1, 0, s, phase);
    endtask

    function automatic logic [7:0] legal_value(input int a);
        int v;
        case (a)
            0, 1: begin
                v = ($urandom % 2 == 0) ? 55 + int'($urandom % 5) : int'($urandom % 60);
                return i2b(v) | ($urandom % 2 == 0 ? 8'h80 : 8'h00);
            end
            2: begin
                if ($urandom % 2 == 0)
                    return 8'h40 | i2b(($urandom % 3 == 0) ? 23 : int'($urandom % 24));
                v = 1 + int'($urandom % 12);
                return i2b(v) | (($urandom % 2 == 0) ? 8'h20 : 8'h00);
            end
            3: return 8'(1 + ($urandom % 7));
            4: return i2b(1 + int'($urandom % 28));
            5: return i2b(1 + int'($urandom % 12));
            6: return i2b(int'($urandom % 100));
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog all: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m[0] = 8'h00; m[1] = 8'h00; m[2] = 8'h40; m[3] = 8'h01;
        m[4] = 8'h01; m[5] = 8'h01; m[6] = 8'h00; m[7] = 8'h00;
        mdiv = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare_all("R1");

        // Random mix of pulses and legal writes.
        for (int k = 0; k < 3000; k++) begin
            int a;
            bit r, w;
            r = ($urandom % 8) != 0;
            w = ($urandom % 30) == 0;
            a = int'($urandom % 8);
            step(r, w, a, legal_value(a), "rand");
        end

        // R4 R6 R7 R8: full rollover at new year's eve, 24-hour mode.
        load(8'h63, 8'h07, 8'h31, 8'h12, 8'h99, 8'h59, 8'h59, "R4");
        pulses(DIV_N, "R8");
        // R5: 11:59:59 PM becomes 12 AM with a day carry.
        load(8'h31, 8'h03, 8'h15, 8'h06, 8'h21, 8'h59, 8'h59, "R5");
        pulses(DIV_N, "R5");
        // R5: 11 AM becomes 12 PM with no day carry.
        load(8'h11, 8'h03, 8'h15, 8'h06, 8'h21, 8'h59, 8'h59, "R5");
        pulses(DIV_N, "R5");
        // R5: 12 PM becomes 1 PM.
        load(8'h32, 8'h03, 8'h15, 8'h06, 8'h21, 8'h59, 8'h59, "R5");
        pulses(DIV_N, "R5");
        // R7: February in a common year, a leap year, and a 30-day month.
        load(8'h63, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59, "R7");
        pulses(DIV_N, "R7");
        load(8'h63, 8'h02, 8'h28, 8'h02, 8'h24, 8'h59, 8'h59, "R7");
        pulses(DIV_N, "R7");
        load(8'h63, 8'h02, 8'h29, 8'h02, 8'h24, 8'h59, 8'h59, "R7");
        pulses(DIV_N, "R7");
        load(8'h63, 8'h02, 8'h30, 8'h04, 8'h24, 8'h59, 8'h59, "R7");
        pulses(DIV_N, "R7");
        // R2: digit carry inside the seconds field.
        load(8'h45, 8'h01, 8'h10, 8'h03, 8'h05, 8'h10, 8'h09, "R2");
        pulses(DIV_N, "R2");
        // R10: a write on the completing pulse discards the advance.
        step(1'b0, 1'b1, 0, 8'h10, "R10");
        pulses(DIV_N - 1, "R10");
        step(1'b1, 1'b1, 1, 8'h22, "R10");
        check("R10", "R10", "sec kept", m[0], 8'h10);
        // R11: a seconds write restarts the divider mid-count.
        pulses(9, "R11");
        step(1'b0, 1'b1, 0, 8'h30, "R11");
        pulses(DIV_N - 1, "R11");
        check("R11", "R11", "sec before", m[0], 8'h30);
        pulses(1, "R11");
        check("R11", "R11", "sec after", m[0], 8'h31);
        // R9: high junk bits are dropped by the masks.
        step(1'b0, 1'b1, 0, 8'hD9, "R9");
        step(1'b0, 1'b1, 1, 8'hC7, "R9");
        step(1'b0, 1'b1, 2, 8'h92, "R9");
        step(1'b0, 1'b1, 3, 8'hF5, "R9");
        step(1'b0, 1'b1, 4, 8'hD5, "R9");
        step(1'b0, 1'b1, 5, 8'hE9, "R9");
        step(1'b0, 1'b1, 7, 8'hFF, "R9");
        // R12: every rate, and disabled.
        for (int rt = 0; rt < 4; rt++) begin
            step(1'b0, 1'b1, 7, 8'h10 | 8'(rt), "R12");
            pulses(DIV_N + 4, "R12");
        end
        step(1'b0, 1'b1, 7, 8'h03, "R12");
        pulses(12, "R12");

        finish_run();
    end

endmodule